// File: doc/BRIEF.md
# Two-Bank Elastic Store Writer

This block fills a 16-position elastic store from a serial bit stream. Each cycle in which the timing strobe is high, the block does three things. It moves the incoming bit into a one-bit input holding stage. It writes the bit that was already in that stage into the store. It advances a 4-bit write address by one. The top address bit picks one of two 8-bit banks. Addresses 0 to 7 land in the low bank and 8 to 15 in the high bank. The lower three bits pick the bit position inside the chosen bank.

The address counts freely and wraps from 15 to 0. An initialization pulse places it at binary 1010, which puts the writer half a store away from a reader that starts near zero. The contents of both banks and the write address are outputs, for the read logic that sits downstream.

A two-state controller tracks whether the holding stage holds a real bit. `WR_EMPTY` is entered at reset. Its only transition leaves on the first strobe that is taken without init, and no store write happens on that strobe. `WR_STREAM` has a single self-transition and writes the held bit on every strobe that is taken.

Top module: `elastic_store_writer`

## Requirements
- R1: After reset, `wr_addr` is 0 and the controller is in `WR_EMPTY`. The first strobe taken after that changes no bank bit.
- R2: A strobe with `init` low raises `wr_addr` by one. With neither strobe nor init, `wr_addr` holds its value.
- R3: The write address wraps from 15 to 0 on a strobe.
- R4: `init` loads `wr_addr` with binary 1010 (decimal 10), whatever the strobe does.
- R5: When `init` and the strobe are both high in a cycle, no bank bit changes and the held bit keeps its old value.
- R6: In `WR_STREAM`, a strobe with `wr_addr` bit 3 equal to 0 writes `bank_lo[wr_addr[2:0]]`.
- R7: In `WR_STREAM`, a strobe with `wr_addr` bit 3 equal to 1 writes `bank_hi[wr_addr[2:0]]`.
- R8: The bit written is the `din` value from the strobe taken before, so stored data trails the input by one strobe.
- R9: A write changes only the addressed bit. Every other bit in both banks keeps its value, and reset does not clear the banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the address, controller and holding stage |
| din | input | 1 | Serial data bit |
| strobe | input | 1 | Timing strobe: take `din`, write the held bit, advance the address |
| init | input | 1 | Initialization preset of the write address |
| bank_lo | output | 8 | Low bank contents (addresses 0 to 7) |
| bank_hi | output | 8 | High bank contents (addresses 8 to 15) |
| wr_addr | output | 4 | Current write address |

## Verification
A wrong address shows on `wr_addr` one cycle after the strobe or init that caused it. It then also puts the next bank write in the wrong place, and that shows in the bank outputs one strobe later. A controller stuck in the wrong state either drops the first write after reset or makes a spurious write. Either fault shows on the very next bank comparison, because the reference model knows every position that was written. A holding stage that captures during init shows as a wrong stored value on the strobe that follows.

// File: rtl/elastic_store_writer_pkg.sv
package elastic_store_writer_pkg;

    // Controller state: is a real bit present in the input holding stage?
    typedef enum logic [0:0] {
        WR_EMPTY  = 1'b0,
        WR_STREAM = 1'b1
    } wr_state_t;

endpackage

// File: rtl/ew_input_stage.sv
module ew_input_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic din,
    output logic held
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (take) begin
            held <= din;
        end
    end

endmodule

// File: rtl/ew_wr_ctrl.sv
module ew_wr_ctrl
    import elastic_store_writer_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned PRESET_VAL = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              init,
    output logic              take,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);

    localparam logic [ADDR_W-1:0] PRESET_ADDR = PRESET_VAL[ADDR_W-1:0];

    wr_state_t state_q;
    wr_state_t state_d;

    // init always overrides the strobe
    assign take = strobe && !init;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_EMPTY:  if (take) state_d = WR_STREAM;
            WR_STREAM: state_d = WR_STREAM;
            default:   state_d = WR_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            WR_EMPTY:  wr_en = 1'b0;
            WR_STREAM: wr_en = take;
            default:   wr_en = 1'b0;
        endcase
    end

    // free-running write pointer with preset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
        end else if (init) begin
            wr_addr <= PRESET_ADDR;
        end else if (strobe) begin
            wr_addr <= wr_addr + 1'b1;
        end
    end

endmodule

// File: rtl/ew_bank.sv
module ew_bank #(
    parameter int unsigned IDX_W = 3,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic             bit_in,
    output logic [DEPTH-1:0] q
);

    // storage is deliberately not reset
    always_ff @(posedge clk) begin
        if (we) begin
            q[idx] <= bit_in;
        end
    end

endmodule

// File: rtl/elastic_store_writer.sv
module elastic_store_writer #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned PRESET_VAL = 10,
    localparam int unsigned IDX_W     = ADDR_W - 1,
    localparam int unsigned BANK_W    = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              strobe,
    input  logic              init,
    output logic [BANK_W-1:0] bank_lo,
    output logic [BANK_W-1:0] bank_hi,
    output logic [ADDR_W-1:0] wr_addr
);

    logic              take;
    logic              wr_en;
    logic              held;
    logic [BANK_W-1:0] bank_q [2];

    ew_wr_ctrl #(
        .ADDR_W     (ADDR_W),
        .PRESET_VAL (PRESET_VAL)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .init    (init),
        .take    (take),
        .wr_en   (wr_en),
        .wr_addr (wr_addr)
    );

    ew_input_stage u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .din   (din),
        .held  (held)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (wr_addr[ADDR_W-1] == 1'(b));
        ew_bank #(
            .IDX_W (IDX_W)
        ) u_bank (
            .clk    (clk),
            .we     (bank_we),
            .idx    (wr_addr[IDX_W-1:0]),
            .bit_in (held),
            .q      (bank_q[b])
        );
    end

    assign bank_lo = bank_q[0];
    assign bank_hi = bank_q[1];

endmodule

// File: rtl/ew_writer_chk.sv
module ew_writer_chk #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned PRESET_VAL = 10,
    localparam int unsigned BANK_W    = 1 << (ADDR_W - 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic              init,
    input logic [BANK_W-1:0] bank_lo,
    input logic [BANK_W-1:0] bank_hi,
    input logic [ADDR_W-1:0] wr_addr
);

    localparam logic [ADDR_W-1:0] PRESET_ADDR = PRESET_VAL[ADDR_W-1:0];

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !init) |=> (wr_addr == $past(wr_addr) + 1'b1));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !init) |=> $stable(wr_addr));

    // R4
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (wr_addr == PRESET_ADDR));

    // R5
    init_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> ($stable(bank_lo) && $stable(bank_hi)));

    // R9
    lo_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr[ADDR_W-1]) |=> $stable(bank_lo));

    // R9
    hi_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_addr[ADDR_W-1]) |=> $stable(bank_hi));

    // R6
    one_bit_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(bank_lo ^ $past(bank_lo)) <= 1));

    // R7
    one_bit_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(bank_hi ^ $past(bank_hi)) <= 1));

endmodule

bind elastic_store_writer ew_writer_chk #(
    .ADDR_W     (ADDR_W),
    .PRESET_VAL (PRESET_VAL)
) u_writer_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .init    (init),
    .bank_lo (bank_lo),
    .bank_hi (bank_hi),
    .wr_addr (wr_addr)
);

// File: tb/test_elastic_store_writer.sv
module test_elastic_store_writer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       strobe = 1'b0;
    logic       init = 1'b0;
    logic [7:0] bank_lo;
    logic [7:0] bank_hi;
    logic [3:0] wr_addr;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int         m_addr = 0;
    bit         m_valid = 0;
    bit         m_held = 0;
    bit         m_lo [8];
    bit         m_hi [8];
    bit         k_lo [8];
    bit         k_hi [8];

    always #2.5 clk = ~clk;

    elastic_store_writer i_elastic_store_writer (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .strobe  (strobe),
        .init    (init),
        .bank_lo (bank_lo),
        .bank_hi (bank_hi),
        .wr_addr (wr_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int xl = 0;
        int xh = 0;
        int al = 0;
        int ah = 0;
        check(int'(wr_addr) == m_addr, {tag, " addr (R2)"}, int'(wr_addr), m_addr);
        for (int i = 0; i < 8; i++) begin
            if (k_lo[i]) begin
                xl |= int'(m_lo[i]) << i;
                al |= int'(bank_lo[i]) << i;
            end
            if (k_hi[i]) begin
                xh |= int'(m_hi[i]) << i;
                ah |= int'(bank_hi[i]) << i;
            end
        end
        check(al == xl, {tag, " bank_lo (R6)"}, al, xl);
        check(ah == xh, {tag, " bank_hi (R7)"}, ah, xh);
    endtask

    // drive one cycle, update the model for the coming edge, compare after it
    task automatic step(input bit d, input bit s, input bit i, input string tag);
        din = d;
        strobe = s;
        init = i;
        @(posedge clk);
        if (i) begin
            m_addr = 10;
        end else if (s) begin
            if (m_valid) begin
                if (m_addr < 8) begin
                    m_lo[m_addr] = m_held;
                    k_lo[m_addr] = 1;
                end else begin
                    m_hi[m_addr-8] = m_held;
                    k_hi[m_addr-8] = 1;
                end
            end
            m_held = d;
            m_valid = 1;
            m_addr = (m_addr + 1) % 16;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        strobe = 1'b0;
        init = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_addr = 0;
        m_valid = 0;
        m_held = 0;
        check(wr_addr == 4'd0, "R1 reset addr", int'(wr_addr), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired (R1..R9 unfinished) actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: first strobe only primes the holding stage
        step(1, 1, 0, "R1 prime");
        // R6 R7 R8 R3: fill the whole store and wrap
        for (int n = 0; n < 20; n++) step(1'((n * 5 + 3) >> 1), 1, 0, "R8 fill");
        check(wr_addr == 4'd5, "R3 wrap", int'(wr_addr), 5);
        // R2: idle cycles hold the address
        for (int n = 0; n < 3; n++) step(1, 0, 0, "R2 idle");
        // R4: init alone
        step(0, 0, 1, "R4 preset");
        check(wr_addr == 4'b1010, "R4 preset value", int'(wr_addr), 10);
        // R5: init with strobe, no write, held bit kept
        step(~m_held, 1, 1, "R5 init+strobe");
        check(wr_addr == 4'b1010, "R5 preset wins", int'(wr_addr), 10);
        // R8: alternating pattern, gaps between strobes
        for (int n = 0; n < 24; n++) step(1'(n % 3 == 0), 1'(n % 4 != 2), 0, "R8 pattern");
        // R9 R1: reset mid-stream keeps bank contents, no write on first strobe
        do_reset();
        step(1, 0, 0, "R9 after reset");
        step(~m_lo[0], 1, 0, "R1 no write after reset");
        for (int n = 0; n < 18; n++) step(1'(n[0] ^ n[2]), 1, 0, "R9 refill");
        step(0, 1, 1, "R5 again");
        for (int n = 0; n < 10; n++) step(1'(n[1]), 1, 0, "R3 from preset");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule